// File: doc/BRIEF.md
# Configuration Read Fixup Shim

This block sits in front of a configuration-space backend that can only return whole, dword-aligned 32-bit words. A requester asks for one, two or four bytes at any byte offset of one function. The shim fetches the containing dword, repairs a few words of the capability chain and returns the requested bytes. The repairs bypass the MSI entry, fill in the PME interrupt vector when the hardware reports zero, and report a table size for MSI-X that depends on a second word. It also makes up a complete Enhanced Allocation capability whose three entry words come from registers loaded at bring-up.

Requests and responses each use a valid/ready pair. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the shim is idle, so only one read is ever in flight. A response is held stable, with `rsp_valid` high, until the requester raises `rsp_ready`; holding `rsp_ready` low stalls the shim. The backend read port has its own handshake. The address is held until `be_req_ready` is high. The backend then returns the dword later, as a one-cycle `be_rsp_valid` pulse.

Top module: `cfg_fixup_shim`

## Requirements
- R1: A request whose function number is nonzero, or whose byte offset is 2048 or more, gets a response with `rsp_notfound` = 1 and `rsp_data` = 0, and starts no backend fetch.
- R2: Every backend fetch uses an address with its two low bits cleared. An ordinary request starts exactly one fetch, at its own aligned offset.
- R3: At aligned offset 0x40, bits 15:8 of the returned dword read 0x70 and every other bit is the backend value.
- R4: At aligned offset 0x70, if backend bits 29:25 are zero the field reads 2; otherwise the backend dword is returned unchanged.
- R5: At aligned offset 0xB0 the shim makes two fetches, first 0xB0 and then 0x70. The result is (first & 0xC00000FF), OR-ed with 0x0003BC00 if bits 29:25 of the second are zero, else with 0x0001BC00.
- R6: Aligned offsets 0xB4, 0xB8, 0xBC, 0xC0 and 0xC4 return 0x00000000, 0x000F0000, 0x00010014, 0x00000000 and 0x80FF0003. No backend fetch is made.
- R7: Aligned offsets 0xC8, 0xCC and 0xD0 return entry registers 0, 1 and 2, without a backend fetch. A write with `ea_wr_sel` = 0, 1 or 2 loads that entry. All entries are zero after reset.
- R8: An entry write is ignored when `ea_wr_sel` = 3, or when a read is in progress (any cycle where `req_ready` is low).
- R9: `req_size` codes: 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. The repaired dword is shifted right by 8 × offset[1:0]. It is then masked to 8 bits (code 0) or 16 bits (code 1), and not masked for codes 2 and 3.
- R10: Any other accepted offset returns the backend dword unchanged, apart from that shift and mask.
- R11: After reset `req_ready` = 1 and `rsp_valid` = `be_req_valid` = 0. `req_ready` stays low from acceptance until the response is taken. A pending response or backend request holds its value until its ready input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Shim can accept a request |
| req_func | input | FUNC_W | Function number of the request |
| req_offset | input | OFF_W | Byte offset in configuration space |
| req_size | input | 2 | Access size code |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Read data, right-justified |
| rsp_notfound | output | 1 | Request rejected |
| be_req_valid | output | 1 | Backend fetch request |
| be_req_ready | input | 1 | Backend accepts the fetch |
| be_req_addr | output | OFF_W | Aligned backend byte address |
| be_rsp_valid | input | 1 | Backend data strobe |
| be_rsp_data | input | 32 | Backend dword |
| ea_wr_en | input | 1 | Entry register write strobe |
| ea_wr_sel | input | 2 | Entry register select |
| ea_wr_data | input | 32 | Entry register write value |

## Verification
The bench builds the shim with its default 12-bit offset and a limit of 2048. This puts offsets just below the limit (0x7FC), at it (0x800) and at the top of the range (0xFFF) within reach, along with every repaired word in the capability area. The backend model's latency, its ready pattern and the requester's ready pattern are varied. This exercises the second 0xB0 fetch under stalls, checks that a response holds under back-pressure, and tests an entry write while a read is in flight.

// File: rtl/cfg_fixup_pkg.sv
package cfg_fixup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_FETCH2,
    ST_WAIT2,
    ST_RESP
  } fix_state_t;

  localparam int EA_N = 3;

  localparam logic [31:0] OFS_CAPPTR = 32'h0000_0040;
  localparam logic [31:0] OFS_EXPR   = 32'h0000_0070;
  localparam logic [31:0] OFS_MSIX   = 32'h0000_00B0;
  localparam logic [31:0] OFS_SYN_LO = 32'h0000_00B4;
  localparam logic [31:0] OFS_SYN_HI = 32'h0000_00D0;

  function automatic logic is_synth(input logic [31:0] aligned_off);
    return (aligned_off >= OFS_SYN_LO) && (aligned_off <= OFS_SYN_HI);
  endfunction

endpackage

// File: rtl/cfg_fixup_patch.sv
module cfg_fixup_patch
  import cfg_fixup_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic [OFF_W-1:0]         dw_off,
  input  logic [31:0]              raw,
  input  logic [31:0]              aux,
  input  logic [EA_N-1:0][31:0]    ea_vec,
  output logic [31:0]              patched
);

  logic [31:0] off32;
  assign off32 = 32'(dw_off);

  always_comb begin
    patched = raw;
    case (off32)
      OFS_CAPPTR: patched = {raw[31:16], 8'h70, raw[7:0]};
      OFS_EXPR:   patched = (raw[29:25] == 5'd0) ? {raw[31:30], 5'd2, raw[24:0]} : raw;
      OFS_MSIX:   patched = (raw & 32'hC000_00FF) |
                            ((aux[29:25] == 5'd0) ? 32'h0003_BC00 : 32'h0001_BC00);
      32'h0000_00B4: patched = 32'h0000_0000;
      32'h0000_00B8: patched = 32'h000F_0000;
      32'h0000_00BC: patched = 32'h0001_0014;
      32'h0000_00C0: patched = 32'h0000_0000;
      32'h0000_00C4: patched = 32'h80FF_0003;
      32'h0000_00C8: patched = ea_vec[0];
      32'h0000_00CC: patched = ea_vec[1];
      32'h0000_00D0: patched = ea_vec[2];
      default:       patched = raw;
    endcase
  end

endmodule

// File: rtl/cfg_fixup_align.sv
module cfg_fixup_align (
  input  logic [31:0] dword,
  input  logic [1:0]  byte_sel,
  input  logic [1:0]  size_code,
  output logic [31:0] data_out
);

  logic [31:0] shifted;
  assign shifted = dword >> {byte_sel, 3'b000};

  always_comb begin
    case (size_code)
      2'd0:    data_out = {24'd0, shifted[7:0]};
      2'd1:    data_out = {16'd0, shifted[15:0]};
      default: data_out = shifted;
    endcase
  end

endmodule

// File: rtl/cfg_fixup_ctrl.sv
module cfg_fixup_ctrl
  import cfg_fixup_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int FUNC_W    = 3,
  parameter int CFG_LIMIT = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  output logic [OFF_W-1:0]  be_req_addr,
  input  logic              be_rsp_valid,
  input  logic [31:0]       be_rsp_data,
  output logic              idle,
  output logic [OFF_W-1:0]  off_q,
  output logic [OFF_W-1:0]  off_al,
  output logic [1:0]        size_q,
  output logic              nf_q,
  output logic [31:0]       raw_q,
  output logic [31:0]       aux_q
);

  localparam logic [OFF_W-1:0] ALIGN_MASK = ~OFF_W'(3);
  localparam logic [31:0]      LIMIT_U    = 32'(CFG_LIMIT);

  fix_state_t       st_q;
  logic             reject_w;
  logic [OFF_W-1:0] req_al;

  assign req_al   = req_offset & ALIGN_MASK;
  assign off_al   = off_q & ALIGN_MASK;
  assign reject_w = (req_func != '0) || (32'(req_offset) >= LIMIT_U);

  assign req_ready    = (st_q == ST_IDLE);
  assign idle         = (st_q == ST_IDLE);
  assign rsp_valid    = (st_q == ST_RESP);
  assign be_req_valid = (st_q == ST_FETCH) || (st_q == ST_FETCH2);
  assign be_req_addr  = (st_q == ST_FETCH2) ? OFF_W'(OFS_EXPR) : off_al;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      off_q  <= '0;
      size_q <= '0;
      nf_q   <= 1'b0;
      raw_q  <= '0;
      aux_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          off_q  <= req_offset;
          size_q <= req_size;
          nf_q   <= reject_w;
          if (reject_w || is_synth(32'(req_al))) st_q <= ST_RESP;
          else                                   st_q <= ST_FETCH;
        end
        ST_FETCH:  if (be_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (be_rsp_valid) begin
          raw_q <= be_rsp_data;
          st_q  <= (32'(off_al) == OFS_MSIX) ? ST_FETCH2 : ST_RESP;
        end
        ST_FETCH2: if (be_req_ready) st_q <= ST_WAIT2;
        ST_WAIT2: if (be_rsp_valid) begin
          aux_q <= be_rsp_data;
          st_q  <= ST_RESP;
        end
        ST_RESP:   if (rsp_ready) st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_fixup_shim.sv
module cfg_fixup_shim
  import cfg_fixup_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int FUNC_W    = 3,
  parameter int CFG_LIMIT = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_notfound,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  output logic [OFF_W-1:0]  be_req_addr,
  input  logic              be_rsp_valid,
  input  logic [31:0]       be_rsp_data,
  input  logic              ea_wr_en,
  input  logic [1:0]        ea_wr_sel,
  input  logic [31:0]       ea_wr_data
);

  logic                  idle;
  logic [OFF_W-1:0]      off_q;
  logic [OFF_W-1:0]      off_al;
  logic [1:0]            size_q;
  logic                  nf_q;
  logic [31:0]           raw_q;
  logic [31:0]           aux_q;
  logic [EA_N-1:0][31:0] ea_vec;
  logic [31:0]           patched;
  logic [31:0]           aligned_data;

  cfg_fixup_ctrl #(
    .OFF_W(OFF_W), .FUNC_W(FUNC_W), .CFG_LIMIT(CFG_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_func(req_func), .req_offset(req_offset), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_req_addr(be_req_addr),
    .be_rsp_valid(be_rsp_valid), .be_rsp_data(be_rsp_data),
    .idle(idle), .off_q(off_q), .off_al(off_al), .size_q(size_q),
    .nf_q(nf_q), .raw_q(raw_q), .aux_q(aux_q)
  );

  for (genvar g = 0; g < EA_N; g++) begin : g_entry
    logic [31:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q <= '0;
      else if (ea_wr_en && idle && (ea_wr_sel == 2'(g)))
        ent_q <= ea_wr_data;
    end
    assign ea_vec[g] = ent_q;
  end

  cfg_fixup_patch #(.OFF_W(OFF_W)) u_patch (
    .dw_off(off_al), .raw(raw_q), .aux(aux_q), .ea_vec(ea_vec), .patched(patched)
  );

  cfg_fixup_align u_align (
    .dword(patched), .byte_sel(off_q[1:0]), .size_code(size_q), .data_out(aligned_data)
  );

  assign rsp_notfound = nf_q;
  assign rsp_data     = nf_q ? 32'd0 : aligned_data;

endmodule

// File: rtl/cfg_fixup_shim_chk.sv
module cfg_fixup_shim_chk #(
  parameter int OFF_W     = 12,
  parameter int FUNC_W    = 3,
  parameter int CFG_LIMIT = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [FUNC_W-1:0] req_func,
  input logic [OFF_W-1:0]  req_offset,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_data,
  input logic              rsp_notfound,
  input logic              be_req_valid,
  input logic              be_req_ready,
  input logic [OFF_W-1:0]  be_req_addr
);

  logic       rj_q;
  logic [1:0] sz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rj_q <= 1'b0;
      sz_q <= 2'd0;
    end else if (req_valid && req_ready) begin
      rj_q <= (req_func != '0) || (32'(req_offset) >= 32'(CFG_LIMIT));
      sz_q <= req_size;
    end
  end

  AST_BE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid |-> (be_req_addr[1:0] == 2'b00)); // R2
  AST_BE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_valid && !be_req_ready) |=> (be_req_valid && $stable(be_req_addr))); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_notfound))); // R11
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11
  AST_NF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_notfound) |-> (rsp_data == 32'd0)); // R1
  AST_NF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_notfound == rj_q)); // R1
  AST_NO_FETCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid |-> !rj_q); // R1
  AST_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_notfound && sz_q == 2'd0) |-> (rsp_data[31:8] == 24'd0)); // R9
  AST_HALF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_notfound && sz_q == 2'd1) |-> (rsp_data[31:16] == 16'd0)); // R9

endmodule

bind cfg_fixup_shim cfg_fixup_shim_chk #(
  .OFF_W(OFF_W), .FUNC_W(FUNC_W), .CFG_LIMIT(CFG_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_func(req_func), .req_offset(req_offset), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_notfound(rsp_notfound),
  .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
  .be_req_addr(be_req_addr)
);

// File: tb/cfg_fixup_shim_test.sv
module cfg_fixup_shim_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_func = '0;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_notfound;
  logic        be_req_valid;
  logic        be_req_ready = 1'b0;
  logic [11:0] be_req_addr;
  logic        be_rsp_valid = 1'b0;
  logic [31:0] be_rsp_data = '0;
  logic        ea_wr_en = 1'b0;
  logic [1:0]  ea_wr_sel = '0;
  logic [31:0] ea_wr_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_fixup_shim uut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int cyc = 0;
  int be_mode = 0, rsp_mode = 0, fetch_lat = 0;
  int be_cnt = 0;
  int cur_al = 0;
  bit pend = 0;
  int pcnt = 0;
  logic [11:0] paddr = '0;
  logic [31:0] mem [1024];
  logic [31:0] ea_m [3];
  logic [31:0] q_data[$];
  bit          q_nf[$];
  int          q_fetch[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_dw(input int al);
    logic [31:0] raw;
    raw = mem[al >> 2];
    case (al)
      'h40: return (raw & 32'hFFFF00FF) | 32'h0000_7000;
      'h70: return (raw[29:25] == 0) ? (raw | (32'd2 << 25)) : raw;
      'hB0: return (raw & 32'hC00000FF) | ((mem['h70 >> 2][29:25] == 0) ? 32'h0003BC00 : 32'h0001BC00);
      'hB4: return 32'h0;
      'hB8: return 32'h000F0000;
      'hBC: return 32'h00010014;
      'hC0: return 32'h0;
      'hC4: return 32'h80FF0003;
      'hC8: return ea_m[0];
      'hCC: return ea_m[1];
      'hD0: return ea_m[2];
      default: return raw;
    endcase
  endfunction

  // Backend model and response checker, evaluated away from the active edge.
  always @(negedge clk) if (rst_n) begin
    cyc++;
    be_rsp_valid = 1'b0;
    if (pend) begin
      if (pcnt == 0) begin
        be_rsp_valid = 1'b1;
        be_rsp_data  = mem[paddr[11:2]];
        pend = 0;
      end else pcnt--;
    end
    be_req_ready = (be_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    rsp_ready    = (rsp_mode == 0) ? 1'b1 : ((cyc % 4) == 1);
    if (be_req_valid && be_req_ready) begin
      int ea;
      ea = (be_cnt == 0) ? cur_al : 'h70;
      chk(be_req_addr == 12'(ea), "R2 backend address", 32'(be_req_addr), 32'(ea));
      be_cnt++;
      pend  = 1;
      pcnt  = fetch_lat;
      paddr = be_req_addr;
    end
    if (rsp_valid && rsp_ready) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R11 unexpected response", rsp_data, 32'h0);
      end else begin
        chk(rsp_data == q_data[0], q_tag[0], rsp_data, q_data[0]);
        chk(rsp_notfound == q_nf[0], {q_tag[0], " notfound"}, 32'(rsp_notfound), 32'(q_nf[0]));
        chk(be_cnt == q_fetch[0], {q_tag[0], " fetch count (R2)"}, 32'(be_cnt), 32'(q_fetch[0]));
        void'(q_data.pop_front()); void'(q_nf.pop_front());
        void'(q_fetch.pop_front()); void'(q_tag.pop_front());
      end
      be_cnt = 0;
    end
  end

  task automatic start_read(input int func, input int off, input int size, input string tag);
    logic [31:0] d;
    int al;
    al = off & ~3;
    if (func != 0 || off >= 2048) begin
      q_data.push_back(32'h0); q_nf.push_back(1'b1); q_fetch.push_back(0);
    end else begin
      d = ref_dw(al) >> (8 * (off & 3));
      if (size == 0) d = d & 32'hFF;
      else if (size == 1) d = d & 32'hFFFF;
      q_data.push_back(d); q_nf.push_back(1'b0);
      q_fetch.push_back((al >= 'hB4 && al <= 'hD0) ? 0 : ((al == 'hB0) ? 2 : 1));
    end
    q_tag.push_back(tag);
    cur_al = al;
    @(negedge clk);
    req_valid = 1'b1; req_func = 3'(func); req_offset = 12'(off); req_size = 2'(size);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (q_data.size() != 0) @(negedge clk);
  endtask

  task automatic rd(input int func, input int off, input int size, input string tag);
    start_read(func, off, size, tag);
    wait_done();
  endtask

  task automatic ea_write(input int sel, input logic [31:0] val);
    @(negedge clk);
    ea_wr_en = 1'b1; ea_wr_sel = 2'(sel); ea_wr_data = val;
    @(negedge clk);
    ea_wr_en = 1'b0;
    if (sel < 3) ea_m[sel] = val;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (32'(i) * 32'h0101_0107) ^ 32'h5A3C_96E1;
    for (int i = 0; i < 3; i++) ea_m[i] = 32'h0;
    mem['h70 >> 2] = 32'hC1F0_1234 & ~(32'h1F << 25);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset req_ready", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 32'h0);
    chk(be_req_valid == 1'b0, "R11 reset be_req_valid", 32'(be_req_valid), 32'h0);

    rd(0, 'h00, 2, "R10 plain dword 0x00");
    rd(0, 'h11, 0, "R9 byte at 0x11");
    rd(0, 'h22, 1, "R9 half at 0x22");
    rd(0, 'h13, 3, "R9 size code 3 at 0x13");
    rd(0, 'h40, 2, "R3 cap pointer dword");
    rd(0, 'h41, 0, "R3 cap pointer byte");
    rd(0, 'h70, 2, "R4 vector zero patched");
    rd(0, 'hB0, 2, "R5 msix zero vector");
    rd(0, 'hB2, 1, "R5 msix half");
    mem['h70 >> 2] = 32'h1A00_5678;
    rd(0, 'h70, 2, "R4 vector nonzero kept");
    rd(0, 'hB0, 2, "R5 msix nonzero vector");
    rd(0, 'hB4, 2, "R6 const B4");
    rd(0, 'hB8, 2, "R6 const B8");
    rd(0, 'hBC, 2, "R6 const BC");
    rd(0, 'hC0, 2, "R6 const C0");
    rd(0, 'hC4, 2, "R6 const C4");
    rd(0, 'hBA, 0, "R6 const byte BA");
    rd(0, 'hC8, 2, "R7 entry0 reset zero");

    ea_write(0, 32'hF000_0002);
    ea_write(1, 32'h000F_FFFC);
    ea_write(2, 32'h0000_87E0);
    rd(0, 'hC8, 2, "R7 entry0");
    rd(0, 'hCC, 2, "R7 entry1");
    rd(0, 'hD0, 2, "R7 entry2");
    rd(0, 'hCD, 0, "R7 entry1 byte");
    ea_write(3, 32'hDEAD_BEEF);
    rd(0, 'hC8, 2, "R8 sel3 ignored entry0");
    rd(0, 'hCC, 2, "R8 sel3 ignored entry1");
    rd(0, 'hD0, 2, "R8 sel3 ignored entry2");

    fetch_lat = 5;
    start_read(0, 'h10, 2, "R10 read during busy write");
    ea_wr_en = 1'b1; ea_wr_sel = 2'd0; ea_wr_data = 32'h1234_5678;
    @(negedge clk);
    ea_wr_en = 1'b0;
    wait_done();
    rd(0, 'hC8, 2, "R8 busy write ignored");

    rd(1, 'h00, 2, "R1 nonzero function");
    rd(0, 'h800, 2, "R1 offset at limit");
    rd(0, 'hFFF, 0, "R1 offset top");
    rd(0, 'h7FC, 2, "R1 offset below limit");

    be_mode = 1; rsp_mode = 1; fetch_lat = 2;
    rd(0, 'hB0, 2, "R11 msix under stalls");
    rd(0, 'h44, 1, "R11 plain half under stalls");
    rd(0, 'h40, 2, "R3 under stalls");
    rd(2, 'h40, 2, "R1 reject under stalls");
    fetch_lat = 0;
    rd(0, 'h73, 0, "R4 byte under stalls");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule